// File: doc/BRIEF.md
# Bus Endian Converter

This block sits between a 32-bit processor data bus whose byte order may be big- or little-endian and an internal bus that is always little-endian. On the way in it translates the request address, the write data and the byte enables. On the way out it turns the read data back into the processor's view. Access sizes are byte, halfword and word.

Two inputs fix the translation. One gives the processor's byte order. The other is a method select, which matters only in big-endian mode: it picks either a byte-lane reversal of the data or a remapping of the low address bits. Both pins are captured while reset is asserted and are ignored after that. All translation is combinational. A result therefore appears in the same cycle as the request that causes it.

Top module: `bus_endian_bridge`

## Requirements
- R1: The translation mode is captured from `big_i` and `swap_sel_i` at every clock edge while `rst` is high. After reset is released, changes on those two pins have no effect on any output until the next reset.
- R2: With `big_i` captured as 0, address, write data, byte enables and read data pass through unchanged, whatever `swap_sel_i` was.
- R3: In lane-swap mode (`big_i`=1, `swap_sel_i`=0), write data bits [8k+7:8k] appear on internal lane 3-k, for k = 0..3.
- R4: In lane-swap mode, byte enable bit k appears on internal byte enable bit 3-k.
- R5: In lane-swap mode, the address passes through unchanged for every size.
- R6: In lane-swap mode, internal read data lane k is returned on processor lane 3-k.
- R7: In address-swap mode (`big_i`=1, `swap_sel_i`=1), a byte access (size code 2'b00) inverts address bits [1:0].
- R8: In address-swap mode, a halfword access (size code 2'b01) inverts address bit [1] and keeps bit [0].
- R9: In address-swap mode, a word access (2'b10) or the reserved code 2'b11 leaves the address unchanged.
- R10: In address-swap mode, write data, byte enables, read data and address bits above bit 1 pass unchanged.
- R11: Every output follows its inputs within the same clock cycle, with no register on the data or address path.
- R12: The size code is forwarded to the internal side unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capturing the mode |
| rst | input | 1 | Synchronous active-high reset; the mode is captured while it is high |
| big_i | input | 1 | Processor byte order: 1 selects big-endian |
| swap_sel_i | input | 1 | Big-endian method: 0 selects lane swap, 1 selects address swap |
| cpu_addr_i | input | ADDR_W | Request address from the processor |
| cpu_size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| cpu_wdata_i | input | 32 | Write data from the processor |
| cpu_be_i | input | 4 | Byte enables from the processor |
| cpu_rdata_o | output | 32 | Read data towards the processor |
| int_addr_o | output | ADDR_W | Translated address on the internal side |
| int_size_o | output | 2 | Size code on the internal side |
| int_wdata_o | output | 32 | Translated write data on the internal side |
| int_be_o | output | 4 | Translated byte enables on the internal side |
| int_rdata_i | input | 32 | Read data from the internal side |

## Verification
Every translated output is due in the same cycle as the request that causes it. The mode takes effect from the first clock edge inside reset. The bench drives each request 1 ns after a rising edge and samples all outputs 1 ns later, well before the next edge, so no edge lies between stimulus and sample. After each reset it drives the mode pins to random values, which shows that the mode captured during reset still governs every later result.

// File: rtl/bec_pkg.sv
package bec_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        XM_PASS = 2'b00,
        XM_LANE = 2'b01,
        XM_ADDR = 2'b10
    } xlate_mode_e;

    typedef struct packed {
        logic lane_en;
        logic addr_en;
    } xlate_ctl_t;

    function automatic xlate_mode_e pick_mode(input logic big, input logic sel);
        if (!big)
            return XM_PASS;
        else if (sel)
            return XM_ADDR;
        else
            return XM_LANE;
    endfunction

    function automatic xlate_ctl_t mode_ctl(input xlate_mode_e m);
        xlate_ctl_t c;
        c.lane_en = (m == XM_LANE);
        c.addr_en = (m == XM_ADDR);
        return c;
    endfunction

    // Offset bits to invert for a big-endian access of the given size.
    function automatic logic [OFS_W-1:0] offset_flip(input acc_size_e sz);
        case (sz)
            SZ_BYTE: return {OFS_W{1'b1}};
            SZ_HALF: return {1'b1, {(OFS_W-1){1'b0}}};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bec_mode_latch.sv
module bec_mode_latch
    import bec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        big_i,
    input  logic        sel_i,
    output xlate_mode_e mode_o
);

    xlate_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= pick_mode(big_i, sel_i);
    end

    assign mode_o = mode_q;

    // R1: the mode is frozen once reset has been released
    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

    // R1: the mode holds a legal encoding outside reset
    p_mode_legal_r1: assert property (@(posedge clk) disable iff (rst)
        mode_q != 2'b11);

endmodule

// File: rtl/bec_lane_rev.sv
module bec_lane_rev #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] d_i,
    input  logic                    en_i,
    output logic [LANES*LANE_W-1:0] d_o
);

    localparam int TOTAL_W = LANES * LANE_W;

    logic [TOTAL_W-1:0] rev;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rev[g*LANE_W +: LANE_W] = d_i[(LANES-1-g)*LANE_W +: LANE_W];
    end

    assign d_o = en_i ? rev : d_i;

endmodule

// File: rtl/bec_addr_munge.sv
module bec_addr_munge
    import bec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              en_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [OFS_W-1:0] flip;

    always_comb begin
        flip = en_i ? offset_flip(acc_size_e'(size_i)) : '0;
        addr_o = {addr_i[ADDR_W-1:OFS_W], addr_i[OFS_W-1:0] ^ flip};
    end

    // R7: byte access inverts both offset bits
    p_byte_flip_r7: assert property (@(posedge clk) disable iff (rst)
        (en_i && size_i == 2'b00) |-> (addr_o[1:0] == ~addr_i[1:0]));

    // R8: halfword access inverts only bit 1
    p_half_flip_r8: assert property (@(posedge clk) disable iff (rst)
        (en_i && size_i == 2'b01) |-> (addr_o[1] != addr_i[1] && addr_o[0] == addr_i[0]));

    // R9: word and reserved sizes leave the address alone
    p_word_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (en_i && size_i[1]) |-> (addr_o == addr_i));

    // R10: bits above the offset never move
    p_upper_keep_r10: assert property (@(posedge clk) disable iff (rst)
        addr_o[ADDR_W-1:OFS_W] == addr_i[ADDR_W-1:OFS_W]);

endmodule

// File: rtl/bus_endian_bridge.sv
module bus_endian_bridge
    import bec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_i,
    input  logic              swap_sel_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [1:0]        cpu_size_i,
    input  logic [31:0]       cpu_wdata_i,
    input  logic [3:0]        cpu_be_i,
    output logic [31:0]       cpu_rdata_o,
    output logic [ADDR_W-1:0] int_addr_o,
    output logic [1:0]        int_size_o,
    output logic [31:0]       int_wdata_o,
    output logic [3:0]        int_be_o,
    input  logic [31:0]       int_rdata_i
);

    xlate_mode_e mode;
    xlate_ctl_t  ctl;

    bec_mode_latch u_mode (
        .clk    (clk),
        .rst    (rst),
        .big_i  (big_i),
        .sel_i  (swap_sel_i),
        .mode_o (mode)
    );

    assign ctl = mode_ctl(mode);

    bec_lane_rev #(.LANES(LANES), .LANE_W(BYTE_W)) u_wdata_rev (
        .d_i  (cpu_wdata_i),
        .en_i (ctl.lane_en),
        .d_o  (int_wdata_o)
    );

    bec_lane_rev #(.LANES(LANES), .LANE_W(1)) u_be_rev (
        .d_i  (cpu_be_i),
        .en_i (ctl.lane_en),
        .d_o  (int_be_o)
    );

    bec_lane_rev #(.LANES(LANES), .LANE_W(BYTE_W)) u_rdata_rev (
        .d_i  (int_rdata_i),
        .en_i (ctl.lane_en),
        .d_o  (cpu_rdata_o)
    );

    bec_addr_munge #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .addr_i (cpu_addr_i),
        .size_i (cpu_size_i),
        .en_i   (ctl.addr_en),
        .addr_o (int_addr_o)
    );

    assign int_size_o = cpu_size_i;

    // R2: little-endian capture passes everything through
    p_pass_all_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == XM_PASS) |-> (int_addr_o == cpu_addr_i && int_wdata_o == cpu_wdata_i
                               && int_be_o == cpu_be_i && cpu_rdata_o == int_rdata_i));

    // R3: outer write lanes exchange in lane-swap mode
    p_lane_wdata_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == XM_LANE) |-> (int_wdata_o[7:0] == cpu_wdata_i[31:24]
                               && int_wdata_o[23:16] == cpu_wdata_i[15:8]));

    // R4: enables reverse in lane-swap mode
    p_lane_be_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == XM_LANE) |-> (int_be_o[0] == cpu_be_i[3] && int_be_o[2] == cpu_be_i[1]));

    // R5: address untouched in lane-swap mode
    p_lane_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == XM_LANE) |-> (int_addr_o == cpu_addr_i));

    // R6: read lanes reverse in lane-swap mode
    p_lane_rdata_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == XM_LANE) |-> (cpu_rdata_o[31:24] == int_rdata_i[7:0]
                               && cpu_rdata_o[15:8] == int_rdata_i[23:16]));

    // R10: data and enables untouched in address-swap mode
    p_addr_data_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == XM_ADDR) |-> (int_wdata_o == cpu_wdata_i && int_be_o == cpu_be_i
                               && cpu_rdata_o == int_rdata_i));

    // R12: size forwarded as is
    p_size_fwd_r12: assert property (@(posedge clk) disable iff (rst)
        int_size_o == cpu_size_i);

endmodule

// File: tb/bus_endian_bridge_bench.sv
module bus_endian_bridge_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          big = 1'b0;
    logic          sel = 1'b0;
    logic [AW-1:0] caddr = '0;
    logic [1:0]    csize = '0;
    logic [31:0]   cwdata = '0;
    logic [3:0]    cbe = '0;
    logic [31:0]   crdata;
    logic [AW-1:0] iaddr;
    logic [1:0]    isize;
    logic [31:0]   iwdata;
    logic [3:0]    ibe;
    logic [31:0]   irdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_endian_bridge #(.ADDR_W(AW)) u_bus_endian_bridge (
        .clk(clk), .rst(rst), .big_i(big), .swap_sel_i(sel),
        .cpu_addr_i(caddr), .cpu_size_i(csize), .cpu_wdata_i(cwdata), .cpu_be_i(cbe),
        .cpu_rdata_o(crdata), .int_addr_o(iaddr), .int_size_o(isize),
        .int_wdata_o(iwdata), .int_be_o(ibe), .int_rdata_i(irdata)
    );

    function automatic logic [31:0] rev32(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [3:0] rev4(input logic [3:0] b);
        return {b[0], b[1], b[2], b[3]};
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input logic [1:0] s,
                                               input bit amode);
        if (!amode) return a;
        case (s)
            2'b00:   return a ^ 32'h3;
            2'b01:   return a ^ 32'h2;
            default: return a;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ms: captured big, ss: captured select
    task automatic one_txn(input bit ms, input bit ss, input logic [AW-1:0] a,
                           input logic [1:0] s, input logic [31:0] w,
                           input logic [3:0] b, input logic [31:0] r);
        bit lane;
        bit amode;
        string tag_a;
        string tag_d;
        lane  = ms && !ss;
        amode = ms && ss;
        @(posedge clk);
        #1;
        caddr = a; csize = s; cwdata = w; cbe = b; irdata = r;
        #1; // R11: sampled before the next edge
        if (!ms) begin
            tag_a = "R2";
            tag_d = "R2";
        end else if (lane) begin
            tag_a = "R5";
            tag_d = "R3";
        end else begin
            tag_a = (s == 2'b00) ? "R7" : (s == 2'b01) ? "R8" : "R9";
            tag_d = "R10";
        end
        chk(tag_a, iaddr, exp_addr(a, s, amode));
        chk(tag_d, iwdata, lane ? rev32(w) : w);
        chk(lane ? "R4" : tag_d, {28'd0, ibe}, {28'd0, lane ? rev4(b) : b});
        chk(lane ? "R6" : tag_d, crdata, lane ? rev32(r) : r);
        chk("R12", {30'd0, isize}, {30'd0, s});
    endtask

    task automatic run_mode(input bit ms, input bit ss);
        rst = 1'b1;
        big = ms;
        sel = ss;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: disturb the mode pins after reset
        big = ~ms;
        sel = ~ss;
        // directed: every size against every offset
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 4; o++) begin
                one_txn(ms, ss, 32'h1000_0000 | o, s[1:0], 32'h1122_3344, 4'b0001, 32'hA1B2_C3D4);
            end
        end
        for (int i = 0; i < 80; i++) begin
            big = 1'($urandom);
            sel = 1'($urandom);
            one_txn(ms, ss, $urandom, 2'($urandom), $urandom, 4'($urandom), $urandom);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(posedge clk);
        run_mode(1'b0, 1'b0);
        run_mode(1'b0, 1'b1);
        run_mode(1'b1, 1'b0);
        run_mode(1'b1, 1'b1);
        // R1: a fresh reset picks up new pins
        run_mode(1'b1, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule